// File: doc/BRIEF.md
# ADC Result Limit Compare and Completion Unit

This unit sits after the converter of an analog-to-digital channel and decides what a finished conversion leaves behind. When the converter reports a finished sample, the unit first zero-extends a narrow (8-bit or 10-bit) sample to 12 bits. With limit checking off, it latches the sample into the result register and raises the completion flag.

With limit checking on, the unit computes the sample minus the programmed threshold. It does this as the sample plus the two's complement of the threshold, in one 13-bit adder. The carry out of that adder shows whether the sample is at or above the threshold. In upper-limit mode a sample at or above the threshold passes; in lower-limit mode a sample below it passes. Only a passing sample stores the 12-bit difference and raises the flag. A failing sample leaves the register and the flag as they were.

The flag drives an interrupt line through an enable. Software drops the flag by reading the result or by writing the control register. Address decoding and the converter itself lie outside this unit.

Top module: `adc_result_cmp`

## Requirements
- R1: After reset, `result_q` is 0, `done_flag` is 0 and `irq` is 0.
- R2: With `cmp_en` = 0, a `conv_done` pulse stores the zero-extended sample in `result_q` and sets `done_flag`, both visible one clock later.
- R3: `res_mode` selects the sample width: 2'b00 keeps `conv_data[7:0]`, 2'b01 keeps `conv_data[9:0]`, and 2'b10 or 2'b11 keeps all 12 bits. Bits above the selected width are taken as 0 before any storing or comparing.
- R4: With `cmp_en` = 1 and `cmp_upper` = 1, a sample greater than or equal to `limit_val` stores (sample − `limit_val`) mod 4096 and sets `done_flag`.
- R5: With `cmp_en` = 1 and `cmp_upper` = 0, a sample less than `limit_val` stores (sample − `limit_val`) mod 4096 and sets `done_flag`.
- R6: With `cmp_en` = 1, a sample that fails the selected condition leaves `result_q` and `done_flag` unchanged.
- R7: `irq` is high exactly when `done_flag` is 1 and `irq_en` is 1, in the same cycle.
- R8: A `data_rd` or `ctrl_wr` pulse clears `done_flag` one clock later and does not change `result_q`.
- R9: When a stored completion and a clear request fall in the same cycle, `done_flag` ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe: a conversion has finished |
| conv_data | input | 12 | Raw conversion sample |
| res_mode | input | 2 | Sample width: 00 = 8 bit, 01 = 10 bit, 1x = 12 bit |
| limit_val | input | 12 | Compare threshold |
| cmp_en | input | 1 | Enables limit checking |
| cmp_upper | input | 1 | 1 = upper-limit mode (at or above), 0 = lower-limit mode (below) |
| irq_en | input | 1 | Interrupt enable |
| data_rd | input | 1 | Strobe: result register read |
| ctrl_wr | input | 1 | Strobe: control register written |
| result_q | output | 12 | Result register |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong carry polarity or a wrong mode decode shows up at the first clock edge after the failing `conv_done`. It appears either as a flag that rises when it should stay still, or as a result register that takes a difference it should not. A wrong width mask shows up on the same edge as extra high bits in `result_q`, or as a compare decided on the wrong value. Flag clearing and the set-over-clear priority show on `done_flag` and `irq` one clock after the strobe. The sweeps compare every conversion within one cycle, so any fault shows on the exact edge that caused it.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;
  typedef enum logic [1:0] {
    WMODE_8   = 2'b00,
    WMODE_10  = 2'b01,
    WMODE_12  = 2'b10,
    WMODE_12X = 2'b11
  } wmode_e;
endpackage

// File: rtl/adc_res_mask.sv
module adc_res_mask #(
  parameter int W  = 12,
  parameter int WA = 8,
  parameter int WB = 10
) (
  input  logic [W-1:0] data_in,
  input  logic [1:0]   mode,
  output logic [W-1:0] data_out
);
  import adc_cmp_pkg::*;

  function automatic logic [W-1:0] keep_low(input logic [W-1:0] d, input int n);
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < W; i++) begin
      if (i < n) m[i] = d[i];
    end
    return m;
  endfunction

  always_comb begin
    case (wmode_e'(mode))
      WMODE_8:  data_out = keep_low(data_in, WA);
      WMODE_10: data_out = keep_low(data_in, WB);
      default:  data_out = data_in;
    endcase
  end
endmodule

// File: rtl/adc_cmp_arith.sv
module adc_cmp_arith #(
  parameter int W = 12
) (
  input  logic [W-1:0] sample,
  input  logic [W-1:0] limit,
  output logic [W-1:0] diff,
  output logic         ge
);
  localparam int SW = W + 1;

  function automatic logic [SW-1:0] add_negated(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
  endfunction

  logic [SW-1:0] sum;
  assign sum  = add_negated(sample, limit);
  assign diff = sum[W-1:0];
  assign ge   = sum[SW-1];
endmodule

// File: rtl/adc_cmp_decide.sv
module adc_cmp_decide (
  input  logic cmp_en,
  input  logic upper,
  input  logic ge,
  output logic accept
);
  always_comb begin
    if (!cmp_en)    accept = 1'b1;
    else if (upper) accept = ge;
    else            accept = ~ge;
  end
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         irq_en,
  output logic [W-1:0] result_q,
  output logic         flag,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      flag     <= 1'b0;
    end else begin
      if (load) result_q <= load_val;
      if (load)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  assign irq = flag & irq_en;
endmodule

// File: rtl/adc_result_cmp.sv
module adc_result_cmp #(
  parameter int RES_W = 12,
  parameter int NAR_A = 8,
  parameter int NAR_B = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic [1:0]       res_mode,
  input  logic [RES_W-1:0] limit_val,
  input  logic             cmp_en,
  input  logic             cmp_upper,
  input  logic             irq_en,
  input  logic             data_rd,
  input  logic             ctrl_wr,
  output logic [RES_W-1:0] result_q,
  output logic             done_flag,
  output logic             irq
);
  logic [RES_W-1:0] masked_data;
  logic [RES_W-1:0] diff_val;
  logic [RES_W-1:0] load_val;
  logic             cmp_ge;
  logic             accept;
  logic             load_evt;
  logic             clr_req;

  adc_res_mask #(.W(RES_W), .WA(NAR_A), .WB(NAR_B)) u_mask (
    .data_in (conv_data),
    .mode    (res_mode),
    .data_out(masked_data)
  );

  adc_cmp_arith #(.W(RES_W)) u_arith (
    .sample(masked_data),
    .limit (limit_val),
    .diff  (diff_val),
    .ge    (cmp_ge)
  );

  adc_cmp_decide u_decide (
    .cmp_en(cmp_en),
    .upper (cmp_upper),
    .ge    (cmp_ge),
    .accept(accept)
  );

  assign load_evt = conv_done & accept;
  assign load_val = cmp_en ? diff_val : masked_data;
  assign clr_req  = data_rd | ctrl_wr;

  adc_res_store #(.W(RES_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_evt),
    .load_val(load_val),
    .clr     (clr_req),
    .irq_en  (irq_en),
    .result_q(result_q),
    .flag    (done_flag),
    .irq     (irq)
  );
endmodule

// File: rtl/adc_result_cmp_chk.sv
module adc_result_cmp_chk #(
  parameter int W  = 12,
  parameter int WA = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         conv_done,
  input logic [1:0]   res_mode,
  input logic [W-1:0] limit_val,
  input logic         cmp_en,
  input logic         cmp_upper,
  input logic         irq_en,
  input logic         data_rd,
  input logic         ctrl_wr,
  input logic [W-1:0] result_q,
  input logic         done_flag,
  input logic         irq,
  input logic [W-1:0] masked_data,
  input logic         load_evt
);
  a_r2_raw_store: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !cmp_en |=> done_flag && (result_q == $past(masked_data)));

  a_r3_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_mode == 2'b00) |-> ((masked_data >> WA) == '0));

  a_r4_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && cmp_en && cmp_upper && (masked_data >= limit_val) |-> load_evt);

  a_r5_lower_pass: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && cmp_en && !cmp_upper && (masked_data < limit_val) |-> load_evt);

  a_r6_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !load_evt |=> $stable(result_q));

  a_r6_hold_flag: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !load_evt && !data_rd && !ctrl_wr |=> $stable(done_flag));

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  a_r7_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag && irq_en |-> irq);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd || ctrl_wr) && !load_evt |=> !done_flag && $stable(result_q));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> done_flag);
endmodule

bind adc_result_cmp adc_result_cmp_chk #(.W(RES_W), .WA(NAR_A)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_done  (conv_done),
  .res_mode   (res_mode),
  .limit_val  (limit_val),
  .cmp_en     (cmp_en),
  .cmp_upper  (cmp_upper),
  .irq_en     (irq_en),
  .data_rd    (data_rd),
  .ctrl_wr    (ctrl_wr),
  .result_q   (result_q),
  .done_flag  (done_flag),
  .irq        (irq),
  .masked_data(masked_data),
  .load_evt   (load_evt)
);

// File: tb/adc_result_cmp_test.sv
module adc_result_cmp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [1:0]  res_mode = 2'b10;
  logic [11:0] limit_val = '0;
  logic        cmp_en = 1'b0;
  logic        cmp_upper = 1'b0;
  logic        irq_en = 1'b0;
  logic        data_rd = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [11:0] result_q;
  logic        done_flag;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int exp_res = 0;
  bit exp_flag = 1'b0;

  always #4 clk = ~clk;

  adc_result_cmp uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .res_mode(res_mode), .limit_val(limit_val), .cmp_en(cmp_en),
    .cmp_upper(cmp_upper), .irq_en(irq_en), .data_rd(data_rd),
    .ctrl_wr(ctrl_wr), .result_q(result_q), .done_flag(done_flag), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(result_q == exp_res[11:0], {tag, " result"}, int'(result_q), exp_res);
    check(done_flag == exp_flag, {tag, " flag"}, int'(done_flag), int'(exp_flag));
    check(irq == (exp_flag && irq_en), "R7 irq", int'(irq), int'(exp_flag && irq_en));
  endtask

  function automatic int width_of(input logic [1:0] m);
    if (m == 2'b00) return 256;
    if (m == 2'b01) return 1024;
    return 4096;
  endfunction

  task automatic convert(input int data, input int lim, input bit en, input bit up,
                         input logic [1:0] m, input bit also_clear);
    int s;
    bit pass;
    string tag;
    @(negedge clk);
    conv_data = data[11:0]; limit_val = lim[11:0]; cmp_en = en; cmp_upper = up;
    res_mode = m; conv_done = 1'b1; data_rd = also_clear;
    @(negedge clk);
    conv_done = 1'b0; data_rd = 1'b0;
    s = data % width_of(m);
    if (!en) begin
      pass = 1'b1; tag = (m == 2'b10) ? "R2" : "R3";
    end else begin
      pass = up ? (s >= lim) : (s < lim);
      tag = !pass ? "R6" : (up ? "R4" : "R5");
    end
    if (pass) begin
      exp_res  = en ? ((s - lim + 4096) % 4096) : s;
      exp_flag = 1'b1;
    end else if (also_clear) begin
      exp_flag = 1'b0;
    end
    if (also_clear && pass) tag = "R9";
    check_all(tag);
  endtask

  task automatic clear_by(input bit use_wr);
    @(negedge clk);
    data_rd = !use_wr; ctrl_wr = use_wr;
    @(negedge clk);
    data_rd = 1'b0; ctrl_wr = 1'b0;
    exp_flag = 1'b0;
    check_all("R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lims[8] = '{0, 1, 255, 1000, 2048, 3000, 4094, 4095};
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 / R3: raw storage across widths
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 4096; d += 331) begin
        irq_en = d[0];
        convert(d, 0, 1'b0, 1'b0, m[1:0], 1'b0);
      end
      convert(4095, 0, 1'b0, 1'b0, m[1:0], 1'b0);
    end

    // R4 / R5 / R6: limit sweeps with boundary samples
    for (int li = 0; li < 8; li++) begin
      for (int up = 0; up < 2; up++) begin
        for (int k = -2; k < 10; k++) begin
          int d;
          if (k < 3) d = lims[li] + k;
          else d = (k - 3) * 613;
          if (d < 0 || d > 4095) continue;
          clear_by(k[0]);
          irq_en = ~k[0];
          convert(d, lims[li], 1'b1, up[0], 2'b10, 1'b0);
          convert(d, lims[li], 1'b1, up[0], 2'b10, 1'b0);
        end
      end
    end

    // R3 with compare: narrow sample zero-extended before compare
    clear_by(1'b0);
    convert(12'hF10, 12'h020, 1'b1, 1'b1, 2'b00, 1'b0);
    clear_by(1'b1);
    convert(12'hC05, 12'h300, 1'b1, 1'b0, 2'b01, 1'b0);

    // R9: completion and clear together
    convert(1234, 0, 1'b0, 1'b0, 2'b10, 1'b1);
    convert(100, 50, 1'b1, 1'b1, 2'b10, 1'b1);
    convert(10, 50, 1'b1, 1'b1, 2'b10, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule